// File: doc/BRIEF.md
# Bus Snoop Response Controller

This block sits beside a processor's data cache and watches address tenures on a shared bus. For every snooped tenure it decodes the 5-bit transfer-type code and reads the MEI state of the addressed line, which the tag array returns one cycle after capture. From these it decides whether the local cache must force the bus master to retry, invalidate the line, push a modified line back to memory, or drop its single load-reserve reservation.

Only two transfer types change cache state: the block kill and the write-with-flush. Every other code, including the reserved ones, is ignored. A tenure whose global qualifier is low is never retried and leaves the cache alone. The reservation is still compared on such a tenure, because reservation loss does not depend on coherency scope. A push request stays raised until write-back logic acknowledges it. While it is outstanding, a further modified hit can only be answered with retry.

Top module: `snoop_resp_ctrl`

## Requirements
- R1: During and after a synchronous reset, snp_retry, tag_inval, resv_cancel and push_req are low and no reservation is held.
- R2: A tenure sampled on edge k with snp_valid high takes its tag_state on edge k+1. Its responses appear after edge k+1 and last exactly one cycle. They are low in the cycle between the two edges.
- R3: Only the codes 5'b01100 (block kill) and 5'b00010 (write-with-flush) act. Every other code, including the reserved 5'b00101 and 5'b1xx01, produces no retry, no invalidate, no push and no cancel, whatever the tag state.
- R4: An acting global tenure that hits a line in the exclusive state (tag_state 2'b01) pulses tag_inval with the line's block address (address bits 31:5). It asserts neither retry nor push.
- R5: An acting global tenure that hits a modified line (tag_state 2'b10) while no push is outstanding pulses snp_retry and tag_inval together. It also raises push_req, with push_blk set to the block address.
- R6: push_req and push_blk remain unchanged until push_ack is sampled high while push_req is high. push_req is low in the cycle after that edge.
- R7: While a push is outstanding, an acting global tenure that hits a modified line pulses snp_retry only. There is no invalidate, and push_blk keeps the earlier block.
- R8: An acting tenure that misses (tag_state 2'b00, and 2'b11, which counts as invalid) produces no retry, no invalidate and no push.
- R9: When snp_global is low, no retry, invalidate or push results, even on a modified hit.
- R10: lr_valid stores a reservation on address bits 31:5 of lr_addr, and sc_valid clears it. An acting tenure whose block matches a held reservation pulses resv_cancel and clears it, regardless of snp_global and tag_state.
- R11: No cancel is signalled for a non-acting code, a different block, or when no reservation is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| snp_valid | input | 1 | Snooped address tenure present this cycle |
| snp_ttype | input | 5 | Transfer-type code of the tenure |
| snp_global | input | 1 | Tenure requires coherency action |
| snp_addr | input | 32 | Snooped byte address |
| tag_state | input | 2 | MEI state from tag lookup, one cycle after capture (00 I, 01 E, 10 M, 11 I) |
| lr_valid | input | 1 | Local load-reserve executed |
| lr_addr | input | 32 | Load-reserve byte address |
| sc_valid | input | 1 | Local store-conditional executed |
| push_ack | input | 1 | Write-back logic accepts the push |
| snp_retry | output | 1 | Address retry pulse |
| tag_inval | output | 1 | Set-invalid command pulse to the tag array |
| tag_inval_blk | output | 27 | Block address for the invalidate |
| push_req | output | 1 | Modified-line push request, held until acknowledged |
| push_blk | output | 27 | Block address to push |
| resv_cancel | output | 1 | Reservation lost pulse |

## Verification
The bench sweeps all thirty inert transfer codes against a modified, matching line. A decoder that treated a reserved or synchronising code as acting would produce a retry or a cancel there. It checks that a local tenure on a modified line stays silent, which a design that gated only retry on the global qualifier would fail by invalidating or pushing. It sends a second modified hit while a push is outstanding. A design that re-armed the push would overwrite push_blk or invalidate a line whose data was never written back. It also checks that a reservation is cancelled by a local tenure, and that a reservation cleared by store-conditional or aimed at a different block is not cancelled.

// File: rtl/snp_pkg.sv
package snp_pkg;

  typedef enum logic [4:0] {
    TT_CLEAN    = 5'b00000,
    TT_FLUSH    = 5'b00100,
    TT_SYNC     = 5'b01000,
    TT_KILL     = 5'b01100,
    TT_ORDER    = 5'b10000,
    TT_ECW_WR   = 5'b10100,
    TT_TLB_INV  = 5'b11000,
    TT_ECW_RD   = 5'b11100,
    TT_RSV_SET  = 5'b00001,
    TT_TLB_SYNC = 5'b01001,
    TT_ICINV    = 5'b01101,
    TT_WR_FLUSH = 5'b00010
  } ttype_e;

  typedef enum logic [1:0] {
    MEI_I    = 2'b00,
    MEI_E    = 2'b01,
    MEI_M    = 2'b10,
    MEI_RSVD = 2'b11
  } mei_e;

  typedef enum logic [1:0] {
    CLS_INERT,
    CLS_RESERVED,
    CLS_ACT
  } ttclass_e;

endpackage

// File: rtl/snp_ttype_decode.sv
module snp_ttype_decode
  import snp_pkg::*;
(
  input  logic [4:0] ttype_i,
  output ttclass_e   class_o,
  output logic       acts_o
);

  always_comb begin
    class_o = CLS_RESERVED;
    case (ttype_i)
      TT_KILL, TT_WR_FLUSH:                         class_o = CLS_ACT;
      TT_CLEAN, TT_FLUSH, TT_SYNC, TT_ORDER,
      TT_ECW_WR, TT_TLB_INV, TT_ECW_RD, TT_RSV_SET,
      TT_TLB_SYNC, TT_ICINV:                        class_o = CLS_INERT;
      default:                                      class_o = CLS_RESERVED;
    endcase
  end

  assign acts_o = (class_o == CLS_ACT);

endmodule

// File: rtl/snp_resv.sv
module snp_resv #(
  parameter int BLK_W = 27
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_i,
  input  logic [BLK_W-1:0] set_blk_i,
  input  logic             clr_i,
  input  logic             probe_i,
  input  logic [BLK_W-1:0] probe_blk_i,
  output logic             cancel_o
);

  logic             valid_q;
  logic [BLK_W-1:0] blk_q;
  logic             hit;

  assign hit = valid_q && probe_i && (probe_blk_i == blk_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q  <= 1'b0;
      blk_q    <= '0;
      cancel_o <= 1'b0;
    end else begin
      cancel_o <= hit;
      if (set_i) begin
        valid_q <= 1'b1;
        blk_q   <= set_blk_i;
      end else if (clr_i || hit) begin
        valid_q <= 1'b0;
      end
    end
  end

  assert_cancel_clears_R10: assert property (@(posedge clk) disable iff (rst)
    (hit && !set_i) |=> !valid_q);

  assert_cancel_needs_resv_R11: assert property (@(posedge clk) disable iff (rst)
    cancel_o |-> $past(valid_q));

endmodule

// File: rtl/snp_push_ctl.sv
module snp_push_ctl #(
  parameter int BLK_W = 27
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [BLK_W-1:0] start_blk_i,
  input  logic             ack_i,
  output logic             req_o,
  output logic [BLK_W-1:0] blk_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      req_o <= 1'b0;
      blk_o <= '0;
    end else if (req_o) begin
      if (ack_i) req_o <= 1'b0;
    end else if (start_i) begin
      req_o <= 1'b1;
      blk_o <= start_blk_i;
    end
  end

  assert_push_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (req_o && !ack_i) |=> (req_o && $stable(blk_o)));

  assert_push_drop_R6: assert property (@(posedge clk) disable iff (rst)
    (req_o && ack_i) |=> !req_o);

endmodule

// File: rtl/snoop_resp_ctrl.sv
module snoop_resp_ctrl
  import snp_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int TT_W       = 5,
  parameter int OFF_W      = $clog2(LINE_BYTES),
  parameter int BLK_W      = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              snp_valid,
  input  logic [TT_W-1:0]   snp_ttype,
  input  logic              snp_global,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic [1:0]        tag_state,
  input  logic              lr_valid,
  input  logic [ADDR_W-1:0] lr_addr,
  input  logic              sc_valid,
  input  logic              push_ack,
  output logic              snp_retry,
  output logic              tag_inval,
  output logic [BLK_W-1:0]  tag_inval_blk,
  output logic              push_req,
  output logic [BLK_W-1:0]  push_blk,
  output logic              resv_cancel
);

  // Stage 1: captured tenure, tag lookup in flight
  logic             s1_valid;
  logic [TT_W-1:0]  s1_tt;
  logic             s1_gbl;
  logic [BLK_W-1:0] s1_blk;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_tt    <= '0;
      s1_gbl   <= 1'b0;
      s1_blk   <= '0;
    end else begin
      s1_valid <= snp_valid;
      if (snp_valid) begin
        s1_tt  <= snp_ttype;
        s1_gbl <= snp_global;
        s1_blk <= snp_addr[ADDR_W-1:OFF_W];
      end
    end
  end

  ttclass_e s1_class;
  logic     s1_acts;

  snp_ttype_decode u_dec (
    .ttype_i (s1_tt),
    .class_o (s1_class),
    .acts_o  (s1_acts)
  );

  // Stage 2 decision
  logic act_any, act_gbl, hit_e, hit_m, push_start;
  mei_e st;

  assign st         = mei_e'(tag_state);
  assign act_any    = s1_valid && s1_acts;
  assign act_gbl    = act_any && s1_gbl;
  assign hit_e      = act_gbl && (st == MEI_E);
  assign hit_m      = act_gbl && (st == MEI_M);
  assign push_start = hit_m && !push_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      snp_retry     <= 1'b0;
      tag_inval     <= 1'b0;
      tag_inval_blk <= '0;
    end else begin
      snp_retry <= hit_m;
      tag_inval <= hit_e || push_start;
      if (hit_e || push_start) tag_inval_blk <= s1_blk;
    end
  end

  snp_push_ctl #(.BLK_W(BLK_W)) u_push (
    .clk         (clk),
    .rst         (rst),
    .start_i     (push_start),
    .start_blk_i (s1_blk),
    .ack_i       (push_ack),
    .req_o       (push_req),
    .blk_o       (push_blk)
  );

  snp_resv #(.BLK_W(BLK_W)) u_resv (
    .clk         (clk),
    .rst         (rst),
    .set_i       (lr_valid),
    .set_blk_i   (lr_addr[ADDR_W-1:OFF_W]),
    .clr_i       (sc_valid),
    .probe_i     (act_any),
    .probe_blk_i (s1_blk),
    .cancel_o    (resv_cancel)
  );

  assert_local_no_retry_R9: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && !s1_gbl) |=> (!snp_retry && !tag_inval));

  assert_inert_silent_R3: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && s1_class != CLS_ACT) |=> (!snp_retry && !tag_inval && !resv_cancel));

  assert_retry_only_when_busy_R7: assert property (@(posedge clk) disable iff (rst)
    (snp_retry && !tag_inval) |-> $past(push_req));

  assert_retry_starts_push_R5: assert property (@(posedge clk) disable iff (rst)
    (snp_retry && tag_inval) |-> (push_req && push_blk == tag_inval_blk));

endmodule

// File: tb/snoop_resp_ctrl_bench.sv
module snoop_resp_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        snp_valid = 1'b0;
  logic [4:0]  snp_ttype = '0;
  logic        snp_global = 1'b0;
  logic [31:0] snp_addr = '0;
  logic [1:0]  tag_state = '0;
  logic        lr_valid = 1'b0;
  logic [31:0] lr_addr = '0;
  logic        sc_valid = 1'b0;
  logic        push_ack = 1'b0;
  logic        snp_retry, tag_inval, push_req, resv_cancel;
  logic [26:0] tag_inval_blk, push_blk;

  snoop_resp_ctrl u_snoop_resp_ctrl (
    .clk(clk), .rst(rst), .snp_valid(snp_valid), .snp_ttype(snp_ttype),
    .snp_global(snp_global), .snp_addr(snp_addr), .tag_state(tag_state),
    .lr_valid(lr_valid), .lr_addr(lr_addr), .sc_valid(sc_valid),
    .push_ack(push_ack), .snp_retry(snp_retry), .tag_inval(tag_inval),
    .tag_inval_blk(tag_inval_blk), .push_req(push_req), .push_blk(push_blk),
    .resv_cancel(resv_cancel));

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int          due;
    logic        r, i, c, p;
    logic [26:0] iblk, pblk;
    string       tg;
  } exp_t;
  exp_t sb[$];

  task automatic check(input bit ok, input string tg, input string msg);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s", tg, msg);
    end
  endtask

  // Monitor: pops expected responses when they fall due
  always @(negedge clk) begin
    if (sb.size() > 0 && sb[0].due == cyc) begin
      exp_t e;
      bit ok;
      e = sb.pop_front();
      ok = (snp_retry === e.r) && (tag_inval === e.i) && (resv_cancel === e.c)
         && (push_req === e.p)
         && (!e.i || tag_inval_blk === e.iblk)
         && (!e.p || push_blk === e.pblk);
      check(ok, e.tg, $sformatf("retry/inval/cancel/push act=%b%b%b%b exp=%b%b%b%b iblk act=%h exp=%h pblk act=%h exp=%h",
            snp_retry, tag_inval, resv_cancel, push_req, e.r, e.i, e.c, e.p,
            tag_inval_blk, e.iblk, push_blk, e.pblk));
    end
  end

  task automatic snoop(input logic [4:0] tt, input logic g, input logic [31:0] a,
                       input logic [1:0] ts, input logic r, input logic i,
                       input logic c, input logic p, input logic [26:0] pb,
                       input string tg);
    exp_t e;
    snp_valid = 1; snp_ttype = tt; snp_global = g; snp_addr = a;
    e.due = cyc + 2; e.r = r; e.i = i; e.c = c; e.p = p;
    e.iblk = a[31:5]; e.pblk = pb; e.tg = tg;
    sb.push_back(e);
    @(negedge clk);
    snp_valid = 0; tag_state = ts;
    check(!snp_retry && !tag_inval && !resv_cancel, "R2",
          $sformatf("early response act=%b%b%b exp=000", snp_retry, tag_inval, resv_cancel));
    @(negedge clk);
    tag_state = 2'b00;
  endtask

  task automatic load_reserve(input logic [31:0] a);
    lr_valid = 1; lr_addr = a;
    @(negedge clk);
    lr_valid = 0;
  endtask

  localparam logic [31:0] A = 32'h1000_0040;
  localparam logic [31:0] B = 32'h2000_01A0;
  localparam logic [31:0] C = 32'h3000_0000;

  initial begin
    #(CLK_PERIOD * 20000);
    n_fail++; n_chk++;
    $display("FAIL watchdog: act=timeout exp=completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!snp_retry && !tag_inval && !resv_cancel && !push_req, "R1",
          $sformatf("in reset act=%b%b%b%b exp=0000", snp_retry, tag_inval, resv_cancel, push_req));
    rst = 0;
    @(negedge clk);
    check(!snp_retry && !tag_inval && !resv_cancel && !push_req, "R1",
          $sformatf("after reset act=%b%b%b%b exp=0000", snp_retry, tag_inval, resv_cancel, push_req));
    // R1: no reservation held after reset
    snoop(5'b01100, 1, A, 2'b00, 0, 0, 0, 0, '0, "R1");

    // R3 / R11: every non-acting code, modified matching line, reservation held
    load_reserve(A);
    for (int k = 0; k < 32; k++) begin
      if (k != 5'b01100 && k != 5'b00010)
        snoop(5'(k), 1, A, 2'b10, 0, 0, 0, 0, '0, "R3");
    end

    // R4: exclusive hits
    snoop(5'b01100, 1, B, 2'b01, 0, 1, 0, 0, '0, "R4");
    snoop(5'b00010, 1, C, 2'b01, 0, 1, 0, 0, '0, "R4");

    // R8: misses
    snoop(5'b01100, 1, B, 2'b00, 0, 0, 0, 0, '0, "R8");
    snoop(5'b00010, 1, B, 2'b11, 0, 0, 0, 0, '0, "R8");

    // R9: local tenure on modified line
    snoop(5'b01100, 0, B, 2'b10, 0, 0, 0, 0, '0, "R9");
    snoop(5'b00010, 0, C, 2'b01, 0, 0, 0, 0, '0, "R9");

    // R10: local tenure still cancels the reservation on A (held since sweep)
    snoop(5'b00010, 0, A, 2'b00, 0, 0, 1, 0, '0, "R10");
    // R11: already cancelled, no second cancel
    snoop(5'b01100, 1, A, 2'b00, 0, 0, 0, 0, '0, "R11");

    // R5: modified hit starts a push
    snoop(5'b00010, 1, B, 2'b10, 1, 1, 0, 1, B[31:5], "R5");
    repeat (3) @(negedge clk);
    check(push_req === 1 && push_blk === B[31:5], "R6",
          $sformatf("hold act=%b/%h exp=1/%h", push_req, push_blk, B[31:5]));

    // R7: second modified hit while busy
    snoop(5'b01100, 1, C, 2'b10, 1, 0, 0, 1, B[31:5], "R7");

    // R6: acknowledge
    push_ack = 1;
    @(negedge clk);
    push_ack = 0;
    check(push_req === 0, "R6", $sformatf("after ack act=%b exp=0", push_req));

    // R5: next modified hit starts a new push
    snoop(5'b01100, 1, C, 2'b10, 1, 1, 0, 1, C[31:5], "R5");
    push_ack = 1;
    @(negedge clk);
    push_ack = 0;
    check(push_req === 0, "R6", $sformatf("second ack act=%b exp=0", push_req));

    // R10: store-conditional clears the reservation
    load_reserve(C);
    sc_valid = 1; @(negedge clk); sc_valid = 0;
    snoop(5'b01100, 1, C, 2'b01, 0, 1, 0, 0, '0, "R10");

    // R11: different block does not cancel, matching block does
    load_reserve(C);
    snoop(5'b00010, 1, B, 2'b00, 0, 0, 0, 0, '0, "R11");
    snoop(5'b01100, 1, C + 32'd7, 2'b00, 0, 0, 1, 0, '0, "R10");

    repeat (2) @(negedge clk);
    check(sb.size() == 0, "R2", $sformatf("pending items act=%0d exp=0", sb.size()));
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule